// File: doc/BRIEF.md
# Prioritized Dual-Output Interrupt Controller

The controller collects a set of level-sensitive interrupt lines (128 by default) and steers each one, by its own route bit, to one of two request outputs: a normal request and a fast request. On each output it picks the most urgent source that is pending and not masked. It presents that source's number beside the request line. Software reaches the block through a simple synchronous register bus. Through that bus it can mask and unmask sources bank by bank, force or withdraw pending state, give each source a priority and a route, and set a priority threshold. It can also start a soft reset and watch for it to finish.

Each output holds its choice once it has made one. The reported number and the request line stay frozen until software writes the matching agreement bit. A handler can therefore read the number, service the source and then release the output for the next selection. A source is pending when its input line or its software-trigger bit is high. Lower priority values win, and equal values go to the lower source number.

Top module: `irqc_top`

## Requirements
- R1: After the reset input, every source is masked, every level register reads 0, every software-trigger bit reads 0 and the threshold reads 127. Both request outputs are low with number 0, and the reset-done bit reads 1.
- R2: Source n belongs to bank n>>5, bit n&31. Bank b has registers at word address 0x10+8*b plus an offset: +0 reads the mask, +1 is mask-set and +2 is mask-clear. A 1 written to a bit of mask-set masks that source. A 1 written to a bit of mask-clear unmasks it. A 0 bit in either write leaves that mask bit unchanged.
- R3: In each bank, offset +4 is software-trigger set, +5 is software-trigger clear and +3 reads the trigger bits back. The writes use the same one-hot encoding as R2. A set trigger bit makes its source pending exactly as a high input line does.
- R4: The level register of source n sits at word address 0x40+n. Bit 0 routes the source to the fast output when 1 and to the normal output when 0. Bits 8:2 hold its priority. A read returns the same layout with all other bits 0.
- R5: An output selects, among the pending and unmasked sources routed to it, the one with the lowest priority value. Ties go to the lowest source number. The chosen number appears on the output's number port. It can also be read in the low 7 bits of address 0x03 for the normal output or 0x04 for the fast output.
- R6: When no source qualifies for an output, that output's request is low and its number is 0.
- R7: Once an output has captured a qualifying source, its request and number stay frozen, whatever happens to the sources, until a write to address 0x01 with bit 0 set (normal output) or bit 1 set (fast output). The edge after that write loads a fresh selection.
- R8: Writing 1 to bit 0 of address 0x00 soft-resets the block to the R1 state. Bit 0 of a read of 0x00 reads 0 for status reads on the four clock edges after the write and reads 1 from the fifth edge on.
- R9: The threshold at address 0x02 (7 bits) lets a selection raise its output only when its priority is below the threshold. The value 127 disables the gate and lets every priority through. A blocked selection behaves as in R6.
- R10: A read request returns its data on the read-data port in the cycle after the edge that accepts it. Writes take effect on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NSRC | Level-sensitive interrupt lines |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| irq_o | output | 1 | Normal request output |
| irq_num_o | output | NUM_W | Source number held on the normal output |
| fiq_o | output | 1 | Fast request output |
| fiq_num_o | output | NUM_W | Source number held on the fast output |

## Verification
Both request outputs are registered. An input-line change shows up one clock edge later, and so does any register write that alters eligibility or ordering. The bench drives stimulus at a falling edge, lets exactly one rising edge pass and then samples. After an agreement write it waits for the one edge that loads the new selection. Reads are sampled at the falling edge after the accepting edge. The soft-reset status is read on five consecutive edges so that its fifth-edge release is pinned exactly.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int BANK_W       = 32;
    localparam int PRIO_W       = 7;
    localparam int SOFT_RST_CYC = 4;
    localparam int CNT_W        = $clog2(SOFT_RST_CYC + 1);

    localparam int A_SYS        = 'h00;
    localparam int A_AGREE      = 'h01;
    localparam int A_THR        = 'h02;
    localparam int A_INUM       = 'h03;
    localparam int A_FNUM       = 'h04;
    localparam int A_BANK_BASE  = 'h10;
    localparam int BANK_STRIDE  = 8;
    localparam int A_LVL_BASE   = 'h40;

    typedef enum logic [2:0] {
        BK_MASK = 3'd0,
        BK_MSET = 3'd1,
        BK_MCLR = 3'd2,
        BK_SW   = 3'd3,
        BK_SSET = 3'd4,
        BK_SCLR = 3'd5
    } bank_op_e;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              fiq;
    } lvl_t;

    function automatic logic [31:0] lvl_word(input lvl_t l);
        return {{(32-PRIO_W-2){1'b0}}, l.prio, 1'b0, l.fiq};
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NSRC   = 128,
    parameter int ADDR_W = 8,
    parameter int NUM_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_W-1:0]  irq_num,
    input  logic [NUM_W-1:0]  fiq_num,
    output logic [NSRC-1:0]   mask_q,
    output logic [NSRC-1:0]   sw_q,
    output lvl_t              lvl_q [NSRC],
    output logic [PRIO_W-1:0] thr_q,
    output logic              agree_irq,
    output logic              agree_fiq,
    output logic              soft_clr
);

    localparam int NBANK    = NSRC / BANK_W;
    localparam int BIDX_W   = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam int BANK_END = A_BANK_BASE + NBANK * BANK_STRIDE;
    localparam int LVL_END  = A_LVL_BASE + NSRC;

    logic [CNT_W-1:0]  rst_cnt;
    logic              busy;
    logic              wr_en;
    logic              soft_go;
    logic              bank_hit;
    logic              lvl_hit;
    logic [BIDX_W+2:0] boff;
    logic [BIDX_W-1:0] bidx;
    logic [2:0]        bop;
    logic [NUM_W-1:0]  lidx;
    logic [31:0]       rd_word;

    assign busy     = (rst_cnt != '0);
    assign wr_en    = bus_sel && bus_wr && !busy;
    assign bank_hit = (int'(bus_addr) >= A_BANK_BASE) && (int'(bus_addr) < BANK_END);
    assign lvl_hit  = (int'(bus_addr) >= A_LVL_BASE) && (int'(bus_addr) < LVL_END);
    assign boff     = (BIDX_W+3)'(bus_addr - ADDR_W'(A_BANK_BASE));
    assign bidx     = boff[BIDX_W+2:3];
    assign bop      = boff[2:0];
    assign lidx     = NUM_W'(bus_addr - ADDR_W'(A_LVL_BASE));

    assign soft_go   = wr_en && (bus_addr == ADDR_W'(A_SYS))   && bus_wdata[0];
    assign agree_irq = wr_en && (bus_addr == ADDR_W'(A_AGREE)) && bus_wdata[0];
    assign agree_fiq = wr_en && (bus_addr == ADDR_W'(A_AGREE)) && bus_wdata[1];
    assign soft_clr  = soft_go || busy;

    // soft-reset sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            rst_cnt <= '0;
        end else if (soft_go) begin
            rst_cnt <= CNT_W'(SOFT_RST_CYC);
        end else if (busy) begin
            rst_cnt <= rst_cnt - 1'b1;
        end
    end

    // configuration state
    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            mask_q <= '1;
            sw_q   <= '0;
            thr_q  <= '1;
            for (int i = 0; i < NSRC; i++) begin
                lvl_q[i] <= '0;
            end
        end else if (wr_en) begin
            if (bank_hit) begin
                case (bop)
                    BK_MSET: mask_q[{bidx, 5'b0} +: BANK_W] <= mask_q[{bidx, 5'b0} +: BANK_W] | bus_wdata;
                    BK_MCLR: mask_q[{bidx, 5'b0} +: BANK_W] <= mask_q[{bidx, 5'b0} +: BANK_W] & ~bus_wdata;
                    BK_SSET: sw_q[{bidx, 5'b0} +: BANK_W]   <= sw_q[{bidx, 5'b0} +: BANK_W] | bus_wdata;
                    BK_SCLR: sw_q[{bidx, 5'b0} +: BANK_W]   <= sw_q[{bidx, 5'b0} +: BANK_W] & ~bus_wdata;
                    default: ;
                endcase
            end
            if (lvl_hit) begin
                lvl_q[lidx] <= '{prio: bus_wdata[2 +: PRIO_W], fiq: bus_wdata[0]};
            end
            if (bus_addr == ADDR_W'(A_THR)) begin
                thr_q <= bus_wdata[PRIO_W-1:0];
            end
        end
    end

    // read mux
    always_comb begin
        rd_word = '0;
        if (lvl_hit) begin
            rd_word = lvl_word(lvl_q[lidx]);
        end else if (bank_hit) begin
            case (bop)
                BK_MASK: rd_word = mask_q[{bidx, 5'b0} +: BANK_W];
                BK_SW:   rd_word = sw_q[{bidx, 5'b0} +: BANK_W];
                default: rd_word = '0;
            endcase
        end else if (bus_addr == ADDR_W'(A_SYS)) begin
            rd_word = {31'b0, !busy};
        end else if (bus_addr == ADDR_W'(A_THR)) begin
            rd_word = 32'(thr_q);
        end else if (bus_addr == ADDR_W'(A_INUM)) begin
            rd_word = 32'(irq_num);
        end else if (bus_addr == ADDR_W'(A_FNUM)) begin
            rd_word = 32'(fiq_num);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_sel && !bus_wr) begin
            bus_rdata <= rd_word;
        end
    end

    // R8: a soft reset returns the configuration to its reset values
    a_r8_soft_restores: assert property (@(posedge clk) disable iff (rst)
        soft_go |=> (mask_q == '1 && sw_q == '0 && thr_q == '1));

    // R8: the reset sequence never runs longer than its fixed length
    a_r8_busy_bounded: assert property (@(posedge clk) disable iff (rst)
        rst_cnt <= CNT_W'(SOFT_RST_CYC));

endmodule

// File: rtl/irqc_select.sv
module irqc_select
    import irqc_pkg::*;
#(
    parameter int NSRC  = 128,
    parameter int NUM_W = 7,
    parameter bit ROUTE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              agree_i,
    input  logic [NSRC-1:0]   elig_i,
    input  lvl_t              lvl_i [NSRC],
    input  logic [PRIO_W-1:0] thr_i,
    output logic              valid_o,
    output logic [NUM_W-1:0]  num_o
);

    logic              found;
    logic [PRIO_W-1:0] best_p;
    logic [NUM_W-1:0]  best_i;
    logic              live_valid;
    logic              open_q;

    // linear scan: strict compare keeps the lowest number on ties
    always_comb begin
        found  = 1'b0;
        best_p = '0;
        best_i = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig_i[i] && (lvl_i[i].fiq == ROUTE) &&
                (!found || (lvl_i[i].prio < best_p))) begin
                found  = 1'b1;
                best_p = lvl_i[i].prio;
                best_i = NUM_W'(i);
            end
        end
    end

    assign live_valid = found && ((&thr_i) || (best_p < thr_i));

    // hold register: tracks the live choice until one is captured
    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            open_q  <= 1'b1;
            valid_o <= 1'b0;
            num_o   <= '0;
        end else if (agree_i) begin
            open_q <= 1'b1;
        end else if (open_q) begin
            valid_o <= live_valid;
            num_o   <= live_valid ? best_i : '0;
            if (live_valid) begin
                open_q <= 1'b0;
            end
        end
    end

    // R7: a captured choice stays put until agreement or soft reset
    a_r7_hold_frozen: assert property (@(posedge clk) disable iff (rst)
        (!open_q && !agree_i && !clr_i) |=> ($stable(num_o) && $stable(valid_o)));

    // R7: the output reopens only through an agreement write or soft reset
    a_r7_reopen_cause: assert property (@(posedge clk) disable iff (rst)
        !open_q |=> (!open_q || $past(agree_i) || $past(clr_i)));

    // R6: an idle output reports number zero
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (num_o == '0));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NSRC   = 128,
    parameter int ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NSRC-1:0]          src_in,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic                     irq_o,
    output logic [$clog2(NSRC)-1:0]  irq_num_o,
    output logic                     fiq_o,
    output logic [$clog2(NSRC)-1:0]  fiq_num_o
);

    localparam int NUM_W = $clog2(NSRC);

    logic [NSRC-1:0]   mask_q;
    logic [NSRC-1:0]   sw_q;
    lvl_t              lvl_q [NSRC];
    logic [PRIO_W-1:0] thr_q;
    logic              agree_irq;
    logic              agree_fiq;
    logic              soft_clr;
    logic [NSRC-1:0]   elig;
    logic              agree_w [2];
    logic              valid_w [2];
    logic [NUM_W-1:0]  num_w   [2];

    assign elig       = (src_in | sw_q) & ~mask_q;
    assign agree_w[0] = agree_irq;
    assign agree_w[1] = agree_fiq;

    irqc_regs #(
        .NSRC   (NSRC),
        .ADDR_W (ADDR_W),
        .NUM_W  (NUM_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_num   (num_w[0]),
        .fiq_num   (num_w[1]),
        .mask_q    (mask_q),
        .sw_q      (sw_q),
        .lvl_q     (lvl_q),
        .thr_q     (thr_q),
        .agree_irq (agree_irq),
        .agree_fiq (agree_fiq),
        .soft_clr  (soft_clr)
    );

    for (genvar g = 0; g < 2; g++) begin : g_out
        irqc_select #(
            .NSRC  (NSRC),
            .NUM_W (NUM_W),
            .ROUTE (g == 1)
        ) u_sel (
            .clk     (clk),
            .rst     (rst),
            .clr_i   (soft_clr),
            .agree_i (agree_w[g]),
            .elig_i  (elig),
            .lvl_i   (lvl_q),
            .thr_i   (thr_q),
            .valid_o (valid_w[g]),
            .num_o   (num_w[g])
        );
    end

    assign irq_o     = valid_w[0];
    assign irq_num_o = num_w[0];
    assign fiq_o     = valid_w[1];
    assign fiq_num_o = num_w[1];

endmodule

// File: tb/irqc_top_bench.sv
module irqc_top_bench;

    localparam int NS = 128;

    logic          clk;
    logic          rst;
    logic [NS-1:0] src;
    logic          sel;
    logic          wr;
    logic [7:0]    addr;
    logic [31:0]   wdata;
    logic [31:0]   rdata;
    logic          irq_o;
    logic [6:0]    irq_num;
    logic          fiq_o;
    logic [6:0]    fiq_num;

    int n_chk  = 0;
    int n_fail = 0;
    int b_prio [NS];
    bit b_fiq  [NS];
    int b_thr  = 127;
    logic [31:0] seed = 32'h1234_5678;

    irqc_top u_irqc_top (
        .clk       (clk),
        .rst       (rst),
        .src_in    (src),
        .bus_sel   (sel),
        .bus_wr    (wr),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_o     (irq_o),
        .irq_num_o (irq_num),
        .fiq_o     (fiq_o),
        .fiq_num_o (fiq_num)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // all bus tasks start and end at a falling edge
    task automatic bus_write(input int a, input logic [31:0] d);
        sel = 1'b1; wr = 1'b1; addr = 8'(a); wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input int a, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; addr = 8'(a);
        @(negedge clk);
        d = rdata;
        sel = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_lvl(input int n, input int p, input bit f);
        bus_write('h40 + n, 32'((p << 2) | int'(f)));
        b_prio[n] = p;
        b_fiq[n]  = f;
    endtask

    function automatic int pick(input logic [NS-1:0] pend, input bit rt);
        int best = -1;
        int bp   = 0;
        for (int i = 0; i < NS; i++) begin
            if (pend[i] && b_fiq[i] == rt && (best < 0 || b_prio[i] < bp)) begin
                best = i;
                bp   = b_prio[i];
            end
        end
        if (best >= 0 && !(b_thr == 127 || bp < b_thr)) best = -1;
        return best;
    endfunction

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic check_both(input string tag, input logic [NS-1:0] pend);
        int ei = pick(pend, 1'b0);
        int ef = pick(pend, 1'b1);
        chk({tag, " irq_o"},     int'(irq_o),   int'(ei >= 0));
        chk({tag, " irq_num"},   int'(irq_num), (ei < 0) ? 0 : ei);
        chk({tag, " fiq_o"},     int'(fiq_o),   int'(ef >= 0));
        chk({tag, " fiq_num"},   int'(fiq_num), (ef < 0) ? 0 : ef);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        summary();
        $finish;
    end

    initial begin
        logic [31:0]   d;
        logic [NS-1:0] pend;

        for (int i = 0; i < NS; i++) begin b_prio[i] = 0; b_fiq[i] = 1'b0; end
        rst = 1'b1; src = '0; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 irq_o", int'(irq_o), 0);
        chk("R1 irq_num", int'(irq_num), 0);
        chk("R1 fiq_o", int'(fiq_o), 0);
        for (int b = 0; b < 4; b++) begin
            bus_read('h10 + 8*b, d);
            chk("R1 mask bank", int'(d), int'(32'hFFFF_FFFF));
            bus_read('h13 + 8*b, d);
            chk("R1 trigger bank", int'(d), 0);
        end
        bus_read('h40, d);        chk("R1 level 0", int'(d), 0);
        bus_read('h40 + 127, d);  chk("R1 level 127", int'(d), 0);
        bus_read('h02, d);        chk("R1 threshold", int'(d), 127);
        bus_read('h00, d);        chk("R1 done", int'(d), 1);

        // R2: one-hot mask clear / set, zero bits ignored
        bus_write('h12 + 8, 32'h0000_0010);          // unmask source 36
        bus_read('h10 + 8, d);
        chk("R2 mask after clear", int'(d), int'(32'hFFFF_FFEF));
        src[36] = 1'b1; src[37] = 1'b1;
        tick(1);
        chk("R2 irq_o unmasked 36", int'(irq_o), 1);
        chk("R2 irq_num 36 (37 masked)", int'(irq_num), 36);
        bus_write('h11 + 8, 32'h0);
        bus_read('h10 + 8, d);
        chk("R2 zero mask-set no effect", int'(d), int'(32'hFFFF_FFEF));
        bus_write('h12 + 8, 32'h0);
        bus_read('h10 + 8, d);
        chk("R2 zero mask-clear no effect", int'(d), int'(32'hFFFF_FFEF));
        bus_write('h11 + 8, 32'h0000_0010);
        bus_read('h10 + 8, d);
        chk("R2 mask after set", int'(d), int'(32'hFFFF_FFFF));
        chk("R7 frozen after remask", int'(irq_num), 36);
        for (int b = 0; b < 4; b++) bus_write('h12 + 8*b, 32'hFFFF_FFFF);
        src = '0;
        bus_write('h01, 32'h3);
        tick(1);
        chk("R6 idle irq_o", int'(irq_o), 0);
        chk("R6 idle irq_num", int'(irq_num), 0);

        // R5/R6: single-source sweep with default levels
        for (int n = 0; n < NS; n++) begin
            src = '0; src[n] = 1'b1;
            tick(1);
            chk("R5 sweep irq_o", int'(irq_o), 1);
            chk("R5 sweep irq_num", int'(irq_num), n);
            chk("R4 sweep fiq_o default route", int'(fiq_o), 0);
            src = '0;
            bus_write('h01, 32'h1);
            tick(1);
            chk("R6 sweep released", int'(irq_o), 0);
        end

        // R4: program levels and read back
        for (int n = 0; n < NS; n++) set_lvl(n, (n*37 + 11) % 128, (n % 3) == 0);
        bus_read('h40 + 5, d);
        chk("R4 level 5 word", int'(d), ((5*37 + 11) % 128) << 2);
        bus_read('h40 + 6, d);
        chk("R4 level 6 word", int'(d), (((6*37 + 11) % 128) << 2) | 1);

        // R4: route sweep
        for (int n = 0; n < NS; n++) begin
            src = '0; src[n] = 1'b1;
            bus_write('h01, 32'h3);
            tick(1);
            check_both("R4 route sweep", src);
        end

        // R5: multi-source patterns
        for (int k = 0; k < 150; k++) begin
            for (int w = 0; w < 4; w++) pend[32*w +: 32] = rnd() & rnd() & rnd();
            src = pend;
            bus_write('h01, 32'h3);
            tick(1);
            check_both("R5 pattern", pend);
        end

        // R5: tie goes to the lower number
        set_lvl(10, 3, 1'b0);
        set_lvl(70, 3, 1'b0);
        src = '0; src[70] = 1'b1; src[10] = 1'b1;
        bus_write('h01, 32'h3);
        tick(1);
        chk("R5 tie irq_num", int'(irq_num), 10);

        // R9: threshold gate
        src = '0; src[10] = 1'b1;
        bus_write('h02, 32'd3); b_thr = 3;
        bus_write('h01, 32'h3);
        tick(1);
        chk("R9 blocked irq_o", int'(irq_o), 0);
        chk("R9 blocked irq_num", int'(irq_num), 0);
        bus_write('h02, 32'd4); b_thr = 4;
        tick(1);
        chk("R9 passed irq_o", int'(irq_o), 1);
        chk("R9 passed irq_num", int'(irq_num), 10);
        set_lvl(10, 127, 1'b0);
        bus_write('h02, 32'd127); b_thr = 127;
        bus_write('h01, 32'h1);
        tick(1);
        chk("R9 all-ones passes 127", int'(irq_o), 1);
        bus_write('h02, 32'd126); b_thr = 126;
        bus_write('h01, 32'h1);
        tick(1);
        chk("R9 126 blocks 127", int'(irq_o), 0);
        bus_write('h02, 32'd127); b_thr = 127;

        // R7: freeze until agreement
        set_lvl(21, 0, 1'b0);
        src = '0; src[20] = 1'b1;
        bus_write('h01, 32'h3);
        tick(1);
        chk("R7 captured 20", int'(irq_num), 20);
        src[21] = 1'b1;
        tick(2);
        chk("R7 frozen with better source", int'(irq_num), 20);
        src[20] = 1'b0;
        tick(1);
        chk("R7 frozen after line drops", int'(irq_o), 1);
        chk("R7 frozen number", int'(irq_num), 20);
        bus_write('h01, 32'h2);
        tick(1);
        chk("R7 fast agreement leaves normal", int'(irq_num), 20);
        bus_write('h01, 32'h1);
        tick(1);
        chk("R7 new selection after agreement", int'(irq_num), 21);
        bus_read('h03, d);
        chk("R5 normal number register", int'(d), 21);
        bus_read('h04, d);
        chk("R5 fast number register", int'(d), 0);

        // R3: software trigger
        src = '0;
        bus_write('h14 + 16, 32'h0000_0060);   // sources 69, 70
        bus_read('h13 + 16, d);
        chk("R3 trigger set", int'(d), 'h60);
        bus_write('h15 + 16, 32'h0000_0040);   // drop 70
        bus_read('h13 + 16, d);
        chk("R3 trigger clear", int'(d), 'h20);
        bus_write('h14 + 16, 32'h0);
        bus_read('h13 + 16, d);
        chk("R3 zero set no effect", int'(d), 'h20);
        bus_write('h01, 32'h3);
        tick(1);
        chk("R3 fiq_o from trigger", int'(fiq_o), 1);
        chk("R3 fiq_num 69", int'(fiq_num), 69);
        chk("R3 irq_o idle", int'(irq_o), 0);

        // R8: soft reset, done timing
        bus_write('h00, 32'h1);
        for (int k = 1; k <= 5; k++) begin
            bus_read('h00, d);
            chk("R8 done sequence", int'(d[0]), int'(k == 5));
        end
        chk("R8 fiq_o cleared", int'(fiq_o), 0);
        chk("R8 fiq_num cleared", int'(fiq_num), 0);
        bus_read('h10, d);       chk("R8 mask restored", int'(d), int'(32'hFFFF_FFFF));
        bus_read('h13 + 16, d);  chk("R8 trigger cleared", int'(d), 0);
        bus_read('h40 + 21, d);  chk("R8 level cleared", int'(d), 0);
        bus_read('h02, d);       chk("R10 threshold readback", int'(d), 127);

        summary();
        $finish;
    end

endmodule